// File: doc/BRIEF.md
# Branch-Trace Program Flow Reconstructor

This block rebuilds the path a processor took through its program from a compressed branch-trace stream that has already been split into packets. The stream says little: a synchronisation packet gives a full address, an atom packet says only whether the next branch was taken, an address packet gives the bits of a new address that differ from the last full one, and a context packet announces a process switch. Everything else comes from a preloaded table indexed by address. The table is held outside the block and read combinationally through a lookup port. Each entry gives the first waypoint at or after that address, that waypoint's static branch target, and whether the address is a tracepoint and which ID it carries.

The block tracks a current position, which is the most recently reconstructed address. One table lookup at that position serves two purposes. It decides whether the position is a tracepoint, and it resolves the next atom. Every reconstructed address whose entry is flagged yields one output record made of the entry's tracepoint ID and a timestamp. The output uses a valid/ready handshake. The block performs no address translation, so all positions are logical addresses. A context packet switches the lookup to a different table bank, because two processes may use the same logical addresses.

Top module: `pfr_recon`

## Requirements
- R1: Packet kind encoding on `pkt_kind` is 0 = sync, 1 = atom, 2 = address, 3 = context. An accepted sync packet makes `pkt_addr` the current position (visible on `tbl_addr` one cycle later) and the merge base, and marks the stream as synchronised.
- R2: An accepted atom with `pkt_taken`=1 whose lookup hits moves the position to the entry's `tbl_tgt`.
- R3: An accepted atom with `pkt_taken`=0 whose lookup hits moves the position to the entry's `tbl_wp` plus one, wrapping at AW bits.
- R4: An accepted address packet, which also reports an exception or interrupt, forms the new position as (base AND NOT `pkt_mask`) OR (`pkt_addr` AND `pkt_mask`). The base is the address from the last sync or address packet, and the new value becomes the new base.
- R5: Every new position reached by R1 to R4 is looked up once. An output record is produced only if that lookup has both `tbl_hit` and `tbl_tp` set, and the record carries that entry's `tbl_id`. Records leave in the order their positions were reached.
- R6: A record's timestamp is `pkt_ts` of the packet that reached the position when `cyc_acc`=1 at acceptance. Otherwise it is the number of clock cycles from the release of reset to the acceptance edge.
- R7: An accepted context packet selects table bank `pkt_addr[BW-1:0]` on `tbl_bank` from the next cycle on, whether or not the stream is synchronised. The position does not change.
- R8: Before the first sync, and after an error until the next sync, atom and address packets are consumed and ignored: the position stays the same and no record is produced.
- R9: An atom whose lookup misses (`tbl_hit`=0) sets `err_flag`, which then stays set until reset, and drops synchronisation.
- R10: `ev_id` and `ev_ts` hold steady while `ev_valid`=1 and `ev_ready`=0. `pkt_ready` is low in the cycle after any position update, and it stays low until that position's record has been placed in the output register. After reset `ev_valid`=0, `err_flag`=0, `pkt_ready`=1 and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Trace packet present |
| pkt_ready | output | 1 | Block can take a packet |
| pkt_kind | input | 2 | Packet kind (see R1) |
| pkt_addr | input | AW | Address, partial address bits, or context bank number |
| pkt_mask | input | AW | Which address bits an address packet supplies |
| pkt_taken | input | 1 | Atom outcome: 1 taken |
| pkt_ts | input | TSW | Timestamp carried by the trace |
| cyc_acc | input | 1 | Use the trace timestamp instead of the local count |
| tbl_bank | output | BW | Table bank being read |
| tbl_addr | output | AW | Current position, used as the table index |
| tbl_hit | input | 1 | Table holds an entry for this address |
| tbl_tgt | input | AW | Branch target of the next waypoint |
| tbl_wp | input | AW | Address of the next waypoint |
| tbl_tp | input | 1 | Address is a tracepoint |
| tbl_id | input | IDW | Tracepoint ID |
| ev_valid | output | 1 | Tracepoint record available |
| ev_ready | input | 1 | Consumer takes the record |
| ev_id | output | IDW | Record tracepoint ID |
| ev_ts | output | TSW | Record timestamp |
| err_flag | output | 1 | Sticky lookup-miss error |

## Verification
The bench builds the block with AW=12, IDW=6, TSW=16 and four table banks. It models the table as arithmetic on the bank and the address. With only 12 address bits, random targets and partial-address merges often land on flagged entries and on missing entries. That exercises tracepoint records, lookup misses and resynchronisation many times within one run. A 16-bit timestamp does not wrap over the length of the run, so local timestamps can be compared exactly, and four banks make the bank number visibly change which entries are flagged.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    PK_SYNC = 2'd0,
    PK_ATOM = 2'd1,
    PK_ADDR = 2'd2,
    PK_CTX  = 2'd3
  } pkt_kind_e;
endpackage

// File: rtl/pfr_stamp.sv
module pfr_stamp #(
  parameter int TSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_acc,
  input  logic [TSW-1:0] pkt_ts,
  output logic [TSW-1:0] stamp
);
  logic [TSW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign stamp = cyc_acc ? pkt_ts : cnt_q;
endmodule

// File: rtl/pfr_track.sv
module pfr_track
  import pfr_pkg::*;
#(
  parameter int AW  = 12,
  parameter int BW  = 2,
  parameter int IDW = 6,
  parameter int TSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  pkt_kind_e      kind,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  mask,
  input  logic           taken,
  input  logic [TSW-1:0] stamp,
  input  logic           tbl_hit,
  input  logic [AW-1:0]  tbl_tgt,
  input  logic [AW-1:0]  tbl_wp,
  input  logic           tbl_tp,
  input  logic [IDW-1:0] tbl_id,
  input  logic           slot_free,
  output logic [AW-1:0]  pos,
  output logic [BW-1:0]  bank,
  output logic           busy,
  output logic           synced,
  output logic           err,
  output logic           fire,
  output logic [IDW-1:0] fire_id,
  output logic [TSW-1:0] fire_ts
);
  function automatic logic [AW-1:0] merge_partial(
    input logic [AW-1:0] keep, input logic [AW-1:0] upd, input logic [AW-1:0] sel);
    return (keep & ~sel) | (upd & sel);
  endfunction

  function automatic logic [AW-1:0] step_pos(
    input logic tk, input logic [AW-1:0] tgt, input logic [AW-1:0] wp);
    return tk ? tgt : wp + 1'b1;
  endfunction

  logic [AW-1:0]  base_q, nxt_pos;
  logic [TSW-1:0] ts_q;
  logic           arrive, miss, set_base, chk_done;

  always_comb begin
    arrive   = 1'b0;
    miss     = 1'b0;
    set_base = 1'b0;
    nxt_pos  = pos;
    if (acc) begin
      unique case (kind)
        PK_SYNC: begin
          arrive = 1'b1; set_base = 1'b1; nxt_pos = addr;
        end
        PK_ATOM: if (synced) begin
          if (tbl_hit) begin
            arrive = 1'b1; nxt_pos = step_pos(taken, tbl_tgt, tbl_wp);
          end else begin
            miss = 1'b1;
          end
        end
        PK_ADDR: if (synced) begin
          arrive = 1'b1; set_base = 1'b1; nxt_pos = merge_partial(base_q, addr, mask);
        end
        default: ;
      endcase
    end
  end

  assign fire     = busy && tbl_hit && tbl_tp && slot_free;
  assign chk_done = busy && (!(tbl_hit && tbl_tp) || slot_free);
  assign fire_id  = tbl_id;
  assign fire_ts  = ts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      base_q <= '0;
      bank   <= '0;
      busy   <= 1'b0;
      synced <= 1'b0;
      err    <= 1'b0;
      ts_q   <= '0;
    end else begin
      if (arrive) begin
        pos  <= nxt_pos;
        busy <= 1'b1;
        ts_q <= stamp;
      end else if (chk_done) begin
        busy <= 1'b0;
      end
      if (set_base) base_q <= nxt_pos;
      if (acc && kind == PK_CTX) bank <= addr[BW-1:0];
      if (acc && kind == PK_SYNC) synced <= 1'b1;
      else if (miss)              synced <= 1'b0;
      if (miss) err <= 1'b1;
    end
  end
endmodule

// File: rtl/pfr_evbuf.sv
module pfr_evbuf #(
  parameter int IDW = 6,
  parameter int TSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [IDW-1:0] in_id,
  input  logic [TSW-1:0] in_ts,
  input  logic           ev_ready,
  output logic           slot_free,
  output logic           ev_valid,
  output logic [IDW-1:0] ev_id,
  output logic [TSW-1:0] ev_ts
);
  assign slot_free = !ev_valid || ev_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_id    <= '0;
      ev_ts    <= '0;
    end else if (load) begin
      ev_valid <= 1'b1;
      ev_id    <= in_id;
      ev_ts    <= in_ts;
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pfr_recon.sv
module pfr_recon
  import pfr_pkg::*;
#(
  parameter int AW    = 12,
  parameter int IDW   = 6,
  parameter int TSW   = 16,
  parameter int BANKS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pkt_valid,
  output logic                     pkt_ready,
  input  logic [1:0]               pkt_kind,
  input  logic [AW-1:0]            pkt_addr,
  input  logic [AW-1:0]            pkt_mask,
  input  logic                     pkt_taken,
  input  logic [TSW-1:0]           pkt_ts,
  input  logic                     cyc_acc,
  output logic [$clog2(BANKS)-1:0] tbl_bank,
  output logic [AW-1:0]            tbl_addr,
  input  logic                     tbl_hit,
  input  logic [AW-1:0]            tbl_tgt,
  input  logic [AW-1:0]            tbl_wp,
  input  logic                     tbl_tp,
  input  logic [IDW-1:0]           tbl_id,
  output logic                     ev_valid,
  input  logic                     ev_ready,
  output logic [IDW-1:0]           ev_id,
  output logic [TSW-1:0]           ev_ts,
  output logic                     err_flag
);
  localparam int BW = $clog2(BANKS);

  logic           pkt_acc, busy, synced, fire, slot_free;
  logic [TSW-1:0] stamp, fire_ts;
  logic [IDW-1:0] fire_id;

  assign pkt_ready = !busy;
  assign pkt_acc   = pkt_valid && pkt_ready;

  pfr_stamp #(.TSW(TSW)) u_stamp (
    .clk(clk), .rst_n(rst_n), .cyc_acc(cyc_acc), .pkt_ts(pkt_ts), .stamp(stamp)
  );

  pfr_track #(.AW(AW), .BW(BW), .IDW(IDW), .TSW(TSW)) u_track (
    .clk(clk), .rst_n(rst_n), .acc(pkt_acc), .kind(pkt_kind_e'(pkt_kind)),
    .addr(pkt_addr), .mask(pkt_mask), .taken(pkt_taken), .stamp(stamp),
    .tbl_hit(tbl_hit), .tbl_tgt(tbl_tgt), .tbl_wp(tbl_wp), .tbl_tp(tbl_tp),
    .tbl_id(tbl_id), .slot_free(slot_free), .pos(tbl_addr), .bank(tbl_bank),
    .busy(busy), .synced(synced), .err(err_flag), .fire(fire),
    .fire_id(fire_id), .fire_ts(fire_ts)
  );

  pfr_evbuf #(.IDW(IDW), .TSW(TSW)) u_evbuf (
    .clk(clk), .rst_n(rst_n), .load(fire), .in_id(fire_id), .in_ts(fire_ts),
    .ev_ready(ev_ready), .slot_free(slot_free), .ev_valid(ev_valid),
    .ev_id(ev_id), .ev_ts(ev_ts)
  );
endmodule

// File: rtl/pfr_recon_chk.sv
module pfr_recon_chk #(
  parameter int AW  = 12,
  parameter int BW  = 2,
  parameter int IDW = 6,
  parameter int TSW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pkt_acc,
  input logic           pkt_ready,
  input logic [1:0]     pkt_kind,
  input logic [AW-1:0]  pkt_addr,
  input logic           pkt_taken,
  input logic           synced,
  input logic [BW-1:0]  tbl_bank,
  input logic [AW-1:0]  tbl_addr,
  input logic           tbl_hit,
  input logic [AW-1:0]  tbl_tgt,
  input logic [AW-1:0]  tbl_wp,
  input logic           ev_valid,
  input logic           ev_ready,
  input logic [IDW-1:0] ev_id,
  input logic [TSW-1:0] ev_ts,
  input logic           err_flag
);
  p_sync_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc && pkt_kind == 2'd0 |=> tbl_addr == $past(pkt_addr));

  p_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc && pkt_kind == 2'd1 && synced && tbl_hit && pkt_taken
    |=> tbl_addr == $past(tbl_tgt));

  p_fallthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc && pkt_kind == 2'd1 && synced && tbl_hit && !pkt_taken
    |=> tbl_addr == $past(tbl_wp) + 1'b1);

  p_bank_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc && pkt_kind == 2'd3 |=> tbl_bank == $past(pkt_addr[BW-1:0]) && $stable(tbl_addr));

  p_unsync_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc && !synced && (pkt_kind == 2'd1 || pkt_kind == 2'd2) |=> $stable(tbl_addr));

  p_miss_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc && pkt_kind == 2'd1 && synced && !tbl_hit |=> err_flag && !synced);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_id) && $stable(ev_ts));

  p_stall_after_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc && pkt_kind == 2'd0 |=> !pkt_ready);
endmodule

bind pfr_recon pfr_recon_chk #(.AW(AW), .BW(BW), .IDW(IDW), .TSW(TSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_acc(pkt_acc), .pkt_ready(pkt_ready),
  .pkt_kind(pkt_kind), .pkt_addr(pkt_addr), .pkt_taken(pkt_taken),
  .synced(synced), .tbl_bank(tbl_bank), .tbl_addr(tbl_addr), .tbl_hit(tbl_hit),
  .tbl_tgt(tbl_tgt), .tbl_wp(tbl_wp), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_id(ev_id), .ev_ts(ev_ts), .err_flag(err_flag)
);

// File: tb/pfr_recon_tb.sv
`timescale 1ns/1ps
module pfr_recon_tb;
  localparam int AW = 12, IDW = 6, TSW = 16, BANKS = 4, BW = 2;

  logic clk = 0, rst_n = 0;
  logic pkt_valid = 0, pkt_ready, pkt_taken = 0, cyc_acc = 0;
  logic [1:0] pkt_kind = 0;
  logic [AW-1:0] pkt_addr = 0, pkt_mask = 0;
  logic [TSW-1:0] pkt_ts = 0;
  logic [BW-1:0] tbl_bank;
  logic [AW-1:0] tbl_addr, tbl_tgt, tbl_wp;
  logic tbl_hit, tbl_tp, ev_valid, ev_ready, err_flag;
  logic [IDW-1:0] tbl_id, ev_id;
  logic [TSW-1:0] ev_ts;

  always #10 clk = ~clk;

  pfr_recon #(.AW(AW), .IDW(IDW), .TSW(TSW), .BANKS(BANKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_kind(pkt_kind), .pkt_addr(pkt_addr), .pkt_mask(pkt_mask),
    .pkt_taken(pkt_taken), .pkt_ts(pkt_ts), .cyc_acc(cyc_acc),
    .tbl_bank(tbl_bank), .tbl_addr(tbl_addr), .tbl_hit(tbl_hit),
    .tbl_tgt(tbl_tgt), .tbl_wp(tbl_wp), .tbl_tp(tbl_tp), .tbl_id(tbl_id),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_id(ev_id), .ev_ts(ev_ts),
    .err_flag(err_flag)
  );

  // table model: pure arithmetic on bank and address
  function automatic logic f_hit(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return (a[3:0] ^ {2'b00, b}) != 4'hF;
  endfunction
  function automatic logic [AW-1:0] f_tgt(input logic [BW-1:0] b, input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd13 + 32'(b) * 32'd97 + 32'd5;
    return t[AW-1:0];
  endfunction
  function automatic logic [AW-1:0] f_wp(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return a + AW'(a[1:0]) + AW'(b);
  endfunction
  function automatic logic f_tp(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return a[1:0] == b;
  endfunction
  function automatic logic [IDW-1:0] f_id(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return a[IDW-1:0] ^ {b, 4'b0000};
  endfunction

  always_comb begin
    tbl_hit = f_hit(tbl_bank, tbl_addr);
    tbl_tgt = f_tgt(tbl_bank, tbl_addr);
    tbl_wp  = f_wp(tbl_bank, tbl_addr);
    tbl_tp  = f_tp(tbl_bank, tbl_addr);
    tbl_id  = f_id(tbl_bank, tbl_addr);
  end

  int n_vec = 0, n_bad = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench cycle count since reset release
  logic [TSW-1:0] bc;
  always @(posedge clk) begin
    if (!rst_n) bc <= '0;
    else        bc <= bc + 1'b1;
  end

  // reference model
  logic [AW-1:0] m_pos = 0, m_base = 0;
  logic [BW-1:0] m_bank = 0;
  bit m_sync = 0, m_err = 0;
  logic [IDW-1:0] q_id[$];
  logic [TSW-1:0] q_ts[$];
  int rdy_mode = 0;

  always @(negedge clk) begin
    if (!rst_n) ev_ready = 1'b0;
    else begin
      case (rdy_mode)
        0: ev_ready = 1'b1;
        1: ev_ready = ($urandom % 3) != 0;
        default: ev_ready = 1'b0;
      endcase
      if (ev_valid && ev_ready) begin
        if (q_id.size() == 0) check(0, "R5", "unexpected record id", ev_id, 0);
        else begin
          check(ev_id == q_id[0], "R5", "record id", ev_id, q_id[0]);
          check(ev_ts == q_ts[0], "R6", "record timestamp", ev_ts, q_ts[0]);
          void'(q_id.pop_front());
          void'(q_ts.pop_front());
        end
      end
    end
  end

  task automatic send(input logic [1:0] k, input logic [AW-1:0] a, input logic [AW-1:0] m,
                      input bit tk, input logic [TSW-1:0] ts, input bit ca);
    logic [TSW-1:0] stamp;
    bit arrive;
    string tag;
    @(negedge clk);
    while (!pkt_ready) @(negedge clk);
    pkt_kind = k; pkt_addr = a; pkt_mask = m; pkt_taken = tk;
    pkt_ts = ts; cyc_acc = ca; pkt_valid = 1'b1;
    stamp = ca ? ts : bc;
    arrive = 0;
    tag = "R7";
    case (k)
      2'd0: begin m_pos = a; m_base = a; m_sync = 1; arrive = 1; tag = "R1"; end
      2'd1: if (!m_sync) tag = "R8";
            else if (f_hit(m_bank, m_pos)) begin
              m_pos = tk ? f_tgt(m_bank, m_pos) : f_wp(m_bank, m_pos) + 1'b1;
              arrive = 1; tag = tk ? "R2" : "R3";
            end else begin m_err = 1; m_sync = 0; tag = "R9"; end
      2'd2: if (!m_sync) tag = "R8";
            else begin
              m_pos = (m_base & ~m) | (a & m); m_base = m_pos; arrive = 1; tag = "R4";
            end
      default: m_bank = a[BW-1:0];
    endcase
    if (arrive && f_hit(m_bank, m_pos) && f_tp(m_bank, m_pos)) begin
      q_id.push_back(f_id(m_bank, m_pos));
      q_ts.push_back(stamp);
    end
    @(negedge clk);
    pkt_valid = 1'b0;
    check(tbl_addr == m_pos, tag, "position", tbl_addr, m_pos);
    check(tbl_bank == m_bank, "R7", "bank", tbl_bank, m_bank);
    check(err_flag == m_err, "R9", "error flag", err_flag, m_err);
  endtask

  task automatic drain();
    int w;
    w = 0;
    while ((q_id.size() != 0 || ev_valid) && w < 500) begin @(negedge clk); w++; end
    check(q_id.size() == 0, "R5", "records outstanding", q_id.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check(ev_valid == 0, "R10", "reset ev_valid", ev_valid, 0);
    check(err_flag == 0, "R10", "reset err_flag", err_flag, 0);
    check(pkt_ready == 1, "R10", "reset pkt_ready", pkt_ready, 1);
    check(tbl_addr == 0, "R10", "reset position", tbl_addr, 0);

    // R8: unsynchronised atoms and address packets are dropped
    send(2'd1, 0, 0, 1, 0, 0);
    send(2'd2, 12'h3A4, 12'hFFF, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(ev_valid == 0, "R8", "no record before sync", ev_valid, 0);

    // R1/R5/R6 local stamp, then bank switch R7
    send(2'd0, 12'h100, 0, 0, 0, 0);
    send(2'd3, 12'h001, 0, 0, 0, 0);
    send(2'd0, 12'h101, 0, 0, 16'h1234, 1);
    send(2'd1, 0, 0, 1, 16'h2000, 1);
    send(2'd1, 0, 0, 0, 16'h2001, 1);
    send(2'd2, 12'h00D, 12'h00F, 0, 16'h2002, 1);
    send(2'd2, 12'hA50, 12'hFF0, 0, 0, 0);
    drain();

    // R9: miss on atom, sticky flag, ignore until sync
    send(2'd3, 12'h000, 0, 0, 0, 0);
    send(2'd0, 12'h10F, 0, 0, 0, 0);
    send(2'd1, 0, 0, 1, 0, 0);
    send(2'd1, 0, 0, 0, 0, 0);
    send(2'd2, 12'h444, 12'hFFF, 0, 0, 0);
    send(2'd0, 12'h100, 0, 0, 0, 0);
    drain();

    // R10: output stalled, second record blocks input
    rdy_mode = 2;
    send(2'd0, 12'h100, 0, 0, 16'h0AAA, 1);
    send(2'd0, 12'h204, 0, 0, 16'h0BBB, 1);
    repeat (3) begin
      @(negedge clk);
      check(pkt_ready == 0, "R10", "input held while record pending", pkt_ready, 0);
      check(ev_valid == 1 && ev_id == 6'h00, "R10", "stalled record held", ev_id, 0);
    end
    rdy_mode = 0;
    drain();

    // constrained random mix
    rdy_mode = 1;
    for (int i = 0; i < 2500; i++) begin
      int r;
      logic [1:0] k;
      r = $urandom % 100;
      k = (r < 10) ? 2'd0 : (r < 65) ? 2'd1 : (r < 85) ? 2'd2 : 2'd3;
      send(k, AW'($urandom), AW'($urandom), 1'($urandom), TSW'($urandom), 1'($urandom));
    end
    rdy_mode = 0;
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule